// File: doc/BRIEF.md
# Match-Compare System Timer with Watchdog Reset

This block is a memory-mapped system timer. A 32-bit up-counter advances by one on every clock cycle in which the tick-enable input is high; that input stands for the slow timer clock, already turned into a one-cycle enable. Four 32-bit compare registers watch the counter. When the counter steps onto a compare value, that channel latches a sticky status bit and drives its own interrupt line, but only if the channel's enable bit is set. Software acknowledges an interrupt by writing a one to its status bit.

Channel 3 also serves as a watchdog. Once software arms the watchdog, a channel-3 match sends a one-cycle reset request to the system, whatever the state of its interrupt-enable bit. Software keeps the system alive by moving the channel-3 compare value ahead of the counter. After it is armed, the watchdog stays armed until reset.

The register port is a simple single-cycle one. A write takes effect at the clock edge. Read data is a combinational function of the address.

Top module: `ostmr_timer`

## Requirements
- R1: After synchronous reset, every register reads zero: the counter, all compare registers, status, interrupt enable and watchdog arm. All irq lines and rst_req are low.
- R2: The counter rises by one at each clock edge where tick_en is high. It holds when tick_en is low, and it wraps from 0xFFFFFFFF to 0.
- R3: A write to byte offset 0x10 loads the counter with the written value. The load wins over a tick in the same cycle, and counting then continues from the loaded value.
- R4: Channel i sets status bit i and irq[i] at the clock edge where a tick moves the counter onto compare value i, provided enable bit i is set in that cycle. Loading the counter onto a compare value, or writing a compare value equal to the current count, does not fire the channel.
- R5: A channel whose enable bit is clear never sets its status bit or its irq line, even when the counter steps onto its compare value.
- R6: The status register sits at offset 0x14, with bit i for channel i. A write clears every bit written as 1 and leaves every bit written as 0 unchanged. A match in the same cycle wins over the clear. irq[i] always equals status bit i.
- R7: The interrupt-enable register sits at offset 0x1C. It keeps only written bits 11:0, reads zero above bit 11, and bit i (i < 4) enables channel i.
- R8: The watchdog arm is bit 0 at offset 0x18. Writing 1 arms it. Writing 0 has no effect, so it reads 1 until reset.
- R9: While armed, a channel-3 step match raises rst_req for exactly the one cycle after that edge, even when enable bit 3 is clear. While not armed, rst_req stays low.
- R10: Compare register i sits at byte offset 4*i (0x00 to 0x0C) and reads back what was written. A read of any other offset, including non-word-aligned ones, returns zero, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One count of the timer clock per high cycle |
| bus_wr | input | 1 | Write strobe for bus_addr / bus_wdata |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 4 | Per-channel interrupt lines, level, one per channel |
| rst_req | output | 1 | One-cycle system reset request from the watchdog |

## Verification
The assertions check several rules on every cycle:
- the counter steps, holds and loads as R2 and R3 require;
- an interrupt rises only after a tick and with its enable bit set;
- written-one clears take effect when no match competes;
- the watchdog arm never drops;
- a reset request appears only while the watchdog is armed, and never two cycles in a row.

Only the bench scenarios can show the rest:
- the exact cycle of each channel's match across a sweep of channels and offsets;
- the absence of firing on a counter load or an equal compare write;
- the match across the counter wrap;
- set-over-clear priority;
- the masking of the enable register;
- the zero reads and ignored writes of unmapped offsets.

// File: rtl/ostmr_pkg.sv
package ostmr_pkg;

    localparam logic [7:0] OFS_COUNT  = 8'h10;
    localparam logic [7:0] OFS_STATUS = 8'h14;
    localparam logic [7:0] OFS_WDOG   = 8'h18;
    localparam logic [7:0] OFS_IEN    = 8'h1C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MATCH,
        SEL_COUNT,
        SEL_STATUS,
        SEL_WDOG,
        SEL_IEN
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [1:0] chan;
    } reg_dec_t;

    typedef struct packed {
        logic cnt;
        logic stat;
        logic wdog;
        logic ien;
    } wr_strb_t;

    // Word-aligned decode; compare slots live below the counter offset.
    function automatic reg_dec_t decode_addr(input logic [7:0] a, input int unsigned nch);
        reg_dec_t d;
        d.sel  = SEL_NONE;
        d.chan = a[3:2];
        if (a[1:0] == 2'b00) begin
            if (a < OFS_COUNT) begin
                if ({30'd0, a[3:2]} < nch) d.sel = SEL_MATCH;
            end else begin
                case (a)
                    OFS_COUNT:  d.sel = SEL_COUNT;
                    OFS_STATUS: d.sel = SEL_STATUS;
                    OFS_WDOG:   d.sel = SEL_WDOG;
                    OFS_IEN:    d.sel = SEL_IEN;
                    default:    d.sel = SEL_NONE;
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/ostmr_counter.sv
module ostmr_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_nxt,
    output logic         step
);
    localparam logic [W-1:0] ONE = W'(1);

    // A load suppresses the step so that no match is seen on that edge.
    assign step    = tick && !load;
    assign cnt_nxt = cnt_q + ONE;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (tick) cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/ostmr_chan.sv
module ostmr_chan #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         match_wr,
    input  logic [W-1:0] wdata,
    input  logic         step,
    input  logic [W-1:0] cnt_nxt,
    input  logic         en,
    input  logic         clr,
    output logic [W-1:0] match_q,
    output logic         hit,
    output logic         status_q
);
    // A hit means the counter is stepping onto the compare value this edge.
    assign hit = step && (cnt_nxt == match_q);

    always_ff @(posedge clk) begin
        if (rst)           match_q <= '0;
        else if (match_wr) match_q <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)              status_q <= 1'b0;
        else if (hit && en)   status_q <= 1'b1;
        else if (clr)         status_q <= 1'b0;
    end
endmodule

// File: rtl/ostmr_timer.sv
module ostmr_timer
    import ostmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NCH    = 4,
    parameter int unsigned IEN_W  = 12,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    irq,
    output logic              rst_req
);
    localparam int unsigned WDOG_CH = NCH - 1;

    reg_dec_t               dec;
    wr_strb_t               wr;
    logic [CNT_W-1:0]       cnt_q;
    logic [CNT_W-1:0]       cnt_nxt;
    logic                   step;
    logic [CNT_W-1:0]       match_arr [NCH];
    logic [NCH-1:0]         hit;
    logic [NCH-1:0]         status;
    logic [IEN_W-1:0]       ien_q;
    logic                   wdog_q;
    logic                   rst_req_q;

    assign dec = decode_addr(8'(bus_addr), NCH);

    always_comb begin
        wr.cnt  = bus_wr && (dec.sel == SEL_COUNT);
        wr.stat = bus_wr && (dec.sel == SEL_STATUS);
        wr.wdog = bus_wr && (dec.sel == SEL_WDOG);
        wr.ien  = bus_wr && (dec.sel == SEL_IEN);
    end

    ostmr_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .load     (wr.cnt),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_nxt  (cnt_nxt),
        .step     (step)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        ostmr_chan #(.W(CNT_W)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .match_wr (bus_wr && (dec.sel == SEL_MATCH) && (dec.chan == 2'(i))),
            .wdata    (bus_wdata),
            .step     (step),
            .cnt_nxt  (cnt_nxt),
            .en       (ien_q[i]),
            .clr      (wr.stat && bus_wdata[i]),
            .match_q  (match_arr[i]),
            .hit      (hit[i]),
            .status_q (status[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         ien_q <= '0;
        else if (wr.ien) ien_q <= bus_wdata[IEN_W-1:0];
    end

    // Arm only; a written zero never disarms.
    always_ff @(posedge clk) begin
        if (rst)                          wdog_q <= 1'b0;
        else if (wr.wdog && bus_wdata[0]) wdog_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) rst_req_q <= 1'b0;
        else     rst_req_q <= wdog_q && hit[WDOG_CH];
    end

    always_comb begin
        bus_rdata = '0;
        case (dec.sel)
            SEL_MATCH: begin
                for (int i = 0; i < NCH; i++)
                    if (dec.chan == 2'(i)) bus_rdata = match_arr[i];
            end
            SEL_COUNT:  bus_rdata = cnt_q;
            SEL_STATUS: bus_rdata[NCH-1:0] = status;
            SEL_WDOG:   bus_rdata[0] = wdog_q;
            SEL_IEN:    bus_rdata[IEN_W-1:0] = ien_q;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq     = status;
    assign rst_req = rst_req_q;
endmodule

// File: rtl/ostmr_chk.sv
module ostmr_chk
    import ostmr_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned NCH    = 4,
    parameter int unsigned IEN_W  = 12,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_en,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata,
    input logic [NCH-1:0]    irq,
    input logic              rst_req,
    input logic [CNT_W-1:0]  cnt,
    input logic [IEN_W-1:0]  ien,
    input logic              wdog,
    input logic [NCH-1:0]    hit
);
    logic wr_cnt, wr_stat;
    assign wr_cnt  = bus_wr && (8'(bus_addr) == OFS_COUNT);
    assign wr_stat = bus_wr && (8'(bus_addr) == OFS_STATUS);

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !wr_cnt) |=> (cnt == $past(cnt) + CNT_W'(1)));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !wr_cnt) |=> $stable(cnt));

    a_r3_count_load: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> (cnt == $past(bus_wdata)));

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        // R5: an interrupt only rises with its enable bit set
        a_r5_rise_needs_en: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(ien[i]));

        // R4: an interrupt only rises on a ticking edge
        a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
            $rose(irq[i]) |-> $past(tick_en));

        a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
            (wr_stat && bus_wdata[i] && !hit[i]) |=> !irq[i]);
    end

    a_r8_wdog_sticky: assert property (@(posedge clk) disable iff (rst)
        wdog |=> wdog);

    a_r9_req_needs_arm: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(wdog));

    a_r9_req_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);
endmodule

bind ostmr_timer ostmr_chk #(
    .CNT_W  (CNT_W),
    .NCH    (NCH),
    .IEN_W  (IEN_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .rst_req   (rst_req),
    .cnt       (cnt_q),
    .ien       (ien_q),
    .wdog      (wdog_q),
    .hit       (hit)
);

// File: tb/ostmr_timer_tb.sv
module ostmr_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq;
    logic        rst_req;
    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    ostmr_timer u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .rst_req   (rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of all mapped registers and outputs
        for (int a = 0; a < 32; a += 4) begin
            rd(6'(a), rv);
            chk("R1 register reset", rv, 32'h0);
        end
        chk("R1 irq reset", {28'd0, irq}, 32'h0);
        chk("R1 rst_req reset", {31'd0, rst_req}, 32'h0);

        // R2 and R3: load, then count
        wr(6'h10, 32'd100);
        rd(6'h10, rv); chk("R3 load", rv, 32'd100);
        repeat (5) tick1();
        rd(6'h10, rv); chk("R2 count by ticks", rv, 32'd105);
        repeat (3) @(negedge clk);
        rd(6'h10, rv); chk("R2 hold without tick", rv, 32'd105);
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 32'd50;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        tick_en = 1'b0;
        rd(6'h10, rv); chk("R3 load wins then counts", rv, 32'd51);

        // R4 and R10: sweep channels and compare offsets
        for (int ch = 0; ch < 4; ch++) begin
            logic [31:0] base;
            base = 32'h1000 * ch + 32'd7;
            wr(6'h14, 32'hF);
            wr(6'h1C, 32'd1 << ch);
            wr(6'(4 * ch), base + 32'(ch) + 32'd2);
            rd(6'(4 * ch), rv); chk("R10 compare readback", rv, base + 32'(ch) + 32'd2);
            wr(6'h10, base);
            for (int k = 1; k <= ch + 3; k++) begin
                tick1();
                chk("R4 match timing", {28'd0, irq},
                    (k >= ch + 2) ? (32'd1 << ch) : 32'd0);
                if (ch == 3) chk("R9 no request unarmed", {31'd0, rst_req}, 32'd0);
            end
        end

        // R5: disabled channel does not fire
        wr(6'h14, 32'hF);
        wr(6'h1C, 32'd0);
        wr(6'h10, 32'd300);
        wr(6'h00, 32'd301);
        tick1();
        rd(6'h14, rv); chk("R5 disabled no status", rv, 32'd0);
        chk("R5 disabled no irq", {28'd0, irq}, 32'd0);

        // R6: write-one-to-clear and set-over-clear
        wr(6'h1C, 32'hF);
        for (int i = 0; i < 4; i++) wr(6'(4 * i), 32'd200 + 32'(i));
        wr(6'h10, 32'd199);
        repeat (4) tick1();
        rd(6'h14, rv); chk("R6 all fired", rv, 32'hF);
        wr(6'h14, 32'h5);
        rd(6'h14, rv); chk("R6 w1c selective", rv, 32'hA);
        chk("R6 irq follows status", {28'd0, irq}, 32'hA);
        wr(6'h14, 32'h0);
        rd(6'h14, rv); chk("R6 zero write no effect", rv, 32'hA);
        wr(6'h00, 32'd400);
        wr(6'h10, 32'd399);
        @(negedge clk);
        tick_en = 1'b1; bus_wr = 1'b1; bus_addr = 6'h14; bus_wdata = 32'h1;
        @(negedge clk);
        tick_en = 1'b0; bus_wr = 1'b0;
        rd(6'h14, rv); chk("R6 set wins over clear", rv, 32'hB);

        // R4: no firing on a load or on an equal compare write
        wr(6'h14, 32'hF);
        wr(6'h04, 32'd500);
        wr(6'h10, 32'd500);
        rd(6'h14, rv); chk("R4 load onto match no fire", rv, 32'd0);
        repeat (2) tick1();
        rd(6'h14, rv); chk("R4 past match no fire", rv, 32'd0);
        wr(6'h10, 32'd600);
        wr(6'h08, 32'd600);
        tick1();
        rd(6'h14, rv); chk("R4 equal compare write no fire", rv, 32'd0);

        // R2 and R4: wrap then match
        wr(6'h00, 32'd1);
        wr(6'h10, 32'hFFFF_FFFE);
        tick1(); chk("R4 wrap step1", {28'd0, irq}, 32'd0);
        tick1(); chk("R4 wrap step2", {28'd0, irq}, 32'd0);
        rd(6'h10, rv); chk("R2 wrap to zero", rv, 32'd0);
        tick1(); chk("R4 match after wrap", {28'd0, irq}, 32'd1);

        // R7: enable register width
        wr(6'h1C, 32'hFFFF_FFFF);
        rd(6'h1C, rv); chk("R7 enable keeps 12 bits", rv, 32'h0000_0FFF);

        // R10: unmapped offsets
        wr(6'h20, 32'hFFFF_FFFF);
        wr(6'h3C, 32'hFFFF_FFFF);
        wr(6'h1D, 32'h0);
        rd(6'h20, rv); chk("R10 unmapped read 0x20", rv, 32'd0);
        rd(6'h02, rv); chk("R10 unaligned read", rv, 32'd0);
        rd(6'h1C, rv); chk("R10 unmapped write no effect ien", rv, 32'h0000_0FFF);
        rd(6'h00, rv); chk("R10 unmapped write no effect cmp", rv, 32'd1);
        rd(6'h18, rv); chk("R10 unmapped write no effect wdog", rv, 32'd0);

        // R8 and R9: watchdog
        wr(6'h14, 32'hF);
        wr(6'h18, 32'd1);
        rd(6'h18, rv); chk("R8 armed", rv, 32'd1);
        wr(6'h18, 32'd0);
        rd(6'h18, rv); chk("R8 cannot disarm", rv, 32'd1);
        wr(6'h1C, 32'h7);
        wr(6'h0C, 32'd901);
        wr(6'h10, 32'd900);
        chk("R9 no request before match", {31'd0, rst_req}, 32'd0);
        tick1();
        chk("R9 request on match", {31'd0, rst_req}, 32'd1);
        chk("R9 irq3 stays masked", {28'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R9 request one cycle", {31'd0, rst_req}, 32'd0);

        summary();
        $finish;
    end
endmodule